// File: doc/BRIEF.md
# Nonvolatile Memory Command Launch Controller

This block is the register front end of a nonvolatile memory controller. A host writes a clock divider, loads a command code and its parameter words into a small indexed buffer, and then starts the command by writing 1 to the command-complete bit of the status register. The block checks the request before it starts anything. The divider must have been written since reset. The bus clock must not be flagged as too slow. No error flag may be pending. The command code must be known. No protection violation may be reported. A request that fails a check raises an error flag and does not run.

An accepted command clears the command-complete flag and starts a busy timer, which stands in for the memory array. Program and erase commands count ticks of the divided timing clock, which is meant to run near 1 MHz. The verify command counts bus cycles. When the timer expires, the command-complete flag sets again. While a command is running, writes to the divider, the index and the buffer are dropped.

Top module: `nvm_cmd_front`

## Requirements
- R1: After reset, command-complete reads 1. The access-error flag, the protection-error flag, the divider value, the divider-loaded bit, the index and every buffer word read 0, and `fclk_tick` is low.
- R2: A write to the divider register (address 0) stores the divider field in bits 6:0 and sets the divider-loaded bit (readback bit 15). No later event clears that bit before the next reset.
- R3: `fclk_tick` never pulses while the divider-loaded bit is 0. Once the bit is set, `fclk_tick` pulses once every divider+1 cycles. The count restarts at each divider write and at each launch.
- R4: A program (code 0x01) or erase (code 0x02) launch request made while the divider-loaded bit is 0 sets the access-error flag (status bit 5), and command-complete stays 1.
- R5: A program or erase launch request made while `clk_slow` is high sets the access-error flag and does not start the command.
- R6: A launch request (a write of status bit 7 = 1) made while the access-error or protection-error flag is set starts nothing and changes no flag, and command-complete stays 1.
- R7: Writing 1 to status bit 5 clears the access-error flag, and writing 1 to status bit 4 clears the protection-error flag.
- R8: A launch request with a code in buffer word 0, bits 7:0, other than 0x01, 0x02 or 0x03 sets the access-error flag and starts nothing.
- R9: A program or erase launch request that passes the access checks while `prot_viol` is high sets the protection-error flag (status bit 4) and starts nothing.
- R10: While command-complete is 0, writes to the index register (address 1) and to the buffer (address 2, the word chosen by the index) have no effect.
- R11: While command-complete is 0, writes to the divider register have no effect.
- R12: An accepted command clears command-complete and raises `cmd_busy`. Command-complete reads 1 again after 4 × (divider+1) cycles for program, 6 × (divider+1) cycles for erase, and 5 cycles for verify, counted from the launch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write address: 0 divider, 1 index, 2 buffer, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_raddr | input | 2 | Read address, same map as the write address |
| bus_rdata | output | 16 | Combinational readback of the addressed register |
| prot_viol | input | 1 | Protection violation reported for the target of the buffered command |
| clk_slow | input | 1 | High when the bus clock is below the minimum for program or erase |
| fclk_tick | output | 1 | One-cycle pulse of the divided timing clock |
| cmd_busy | output | 1 | High while an accepted command is running |

## Verification
The assertions check several rules on every cycle. The divider-loaded bit never falls. No tick appears before a divider write. The divider, the index and the buffer words hold still while a command runs. Every launch is preceded by clear error flags and, for timed commands, by a loaded divider on a fast clock. The busy timer runs exactly while command-complete is low. The bench scenarios cover what a per-cycle property cannot show. These are the exact completion latency of each command type at a chosen divider, the tick period, the outcome of each rejected request, and the write-1-to-clear behaviour seen through readback.

// File: rtl/nvm_cmd_pkg.sv
// Shared definitions for the command launch controller: register
// addresses, command codes and status bit positions.
package nvm_cmd_pkg;
    typedef enum logic [1:0] {
        A_DIV  = 2'd0,
        A_IDX  = 2'd1,
        A_BUF  = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    localparam logic [7:0] OP_PROG   = 8'h01;
    localparam logic [7:0] OP_ERASE  = 8'h02;
    localparam logic [7:0] OP_VERIFY = 8'h03;

    localparam int ST_DONE = 7;
    localparam int ST_ACC  = 5;
    localparam int ST_PROT = 4;
endpackage

// File: rtl/nvm_div_gen.sv
// Divider register with a sticky loaded flag, plus the divided tick.
// Assumes: writes are dropped while busy; restart realigns the tick phase.
module nvm_div_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_in,
    input  logic             busy,
    input  logic             restart,
    output logic [DIV_W-1:0] div_q,
    output logic             loaded_q,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             take_wr;

    assign take_wr = div_wr && !busy;
    assign tick    = loaded_q && (cnt_q == div_q);

    // Hold the divider value and the loaded flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            loaded_q <= 1'b0;
        end else if (take_wr) begin
            div_q    <= div_in;
            loaded_q <= 1'b1;
        end
    end

    // Phase counter producing one tick every div_q+1 cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || take_wr || restart) begin
            cnt_q <= '0;
        end else if (loaded_q) begin
            cnt_q <= (cnt_q == div_q) ? '0 : cnt_q + 1'b1;
        end
    end

    p_loaded_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_q |=> loaded_q);
    p_no_tick_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded_q |-> !tick);
    p_div_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(div_q));
endmodule

// File: rtl/nvm_cmd_buf.sv
// Command buffer: an index register and NWORDS data words.
// Word 0 carries the command code. Assumes: writes are dropped while busy.
module nvm_cmd_buf #(
    parameter int DATA_W = 16,
    parameter int NWORDS = 4,
    localparam int IDX_W = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              word_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic [IDX_W-1:0]  idx_q,
    output logic [DATA_W-1:0] sel_word,
    output logic [7:0]        code
);
    logic [DATA_W-1:0] words_q [NWORDS];

    // Index register, frozen while a command runs.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else if (idx_wr && !busy) idx_q <= wdata[IDX_W-1:0];
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        // One buffer word, written when the index selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) words_q[g] <= '0;
            else if (word_wr && !busy && idx_q == IDX_W'(g)) words_q[g] <= wdata;
        end

        p_word_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
            busy |=> $stable(words_q[g]));
    end

    assign sel_word = words_q[idx_q];
    assign code     = words_q[0][7:0];

    p_idx_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(idx_q));
endmodule

// File: rtl/nvm_busy_timer.sv
// Busy-timer stand-in for the array. It counts 'step' pulses after
// a start and pulses 'expire' on the last one. Assumes: start_cnt >= 1.
module nvm_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic             step,
    output logic             active,
    output logic             expire
);
    logic [CNT_W-1:0] left_q;

    assign active = (left_q != '0);
    assign expire = active && step && (left_q == CNT_W'(1));

    // Remaining-units counter.
    always_ff @(posedge clk) begin
        if (!rst_n) left_q <= '0;
        else if (start) left_q <= start_cnt;
        else if (active && step) left_q <= left_q - 1'b1;
    end

    p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);
endmodule

// File: rtl/nvm_cmd_front.sv
// Top of the command launch controller. It decodes register writes,
// validates launch requests, keeps the status flags and drives the busy timer.
// Assumes: DATA_W >= 16 and a single write port, so one register is written per cycle.
module nvm_cmd_front
    import nvm_cmd_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int DIV_W         = 7,
    parameter int NPARAM        = 3,
    parameter int CNT_W         = 8,
    parameter int PROG_TICKS    = 4,
    parameter int ERASE_TICKS   = 6,
    parameter int VERIFY_CYCLES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              prot_viol,
    input  logic              clk_slow,
    output logic              fclk_tick,
    output logic              cmd_busy
);
    localparam int NWORDS = NPARAM + 1;
    localparam int IDX_W  = $clog2(NWORDS);

    logic              done_q, acc_q, prot_q, timed_q;
    logic              stat_wr, go_req, launch;
    logic              is_timed, is_known, set_acc, set_prot;
    logic              div_loaded, timer_active, timer_expire;
    logic [DIV_W-1:0]  div_val;
    logic [IDX_W-1:0]  idx_val;
    logic [DATA_W-1:0] sel_word;
    logic [7:0]        code;
    logic [CNT_W-1:0]  load_cnt;

    assign cmd_busy = !done_q;
    assign stat_wr  = bus_we && (bus_addr == A_STAT);

    nvm_div_gen #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .div_wr(bus_we && bus_addr == A_DIV), .div_in(bus_wdata[DIV_W-1:0]),
        .busy(cmd_busy), .restart(launch),
        .div_q(div_val), .loaded_q(div_loaded), .tick(fclk_tick)
    );

    nvm_cmd_buf #(.DATA_W(DATA_W), .NWORDS(NWORDS)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .idx_wr(bus_we && bus_addr == A_IDX), .word_wr(bus_we && bus_addr == A_BUF),
        .wdata(bus_wdata), .busy(cmd_busy),
        .idx_q(idx_val), .sel_word(sel_word), .code(code)
    );

    nvm_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .start(launch), .start_cnt(load_cnt),
        .step(timed_q ? fclk_tick : 1'b1),
        .active(timer_active), .expire(timer_expire)
    );

    // Launch validation against the flags as they stand before this write.
    always_comb begin
        is_timed = (code == OP_PROG) || (code == OP_ERASE);
        is_known = is_timed || (code == OP_VERIFY);
        go_req   = stat_wr && bus_wdata[ST_DONE] && done_q && !acc_q && !prot_q;
        set_acc  = go_req && (!is_known || (is_timed && (!div_loaded || clk_slow)));
        set_prot = go_req && !set_acc && is_timed && prot_viol;
        launch   = go_req && !set_acc && !set_prot;
        case (code)
            OP_PROG:  load_cnt = CNT_W'(PROG_TICKS);
            OP_ERASE: load_cnt = CNT_W'(ERASE_TICKS);
            default:  load_cnt = CNT_W'(VERIFY_CYCLES);
        endcase
    end

    // Status flags: complete, access error, protection error, timed type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b1;
            acc_q   <= 1'b0;
            prot_q  <= 1'b0;
            timed_q <= 1'b0;
        end else begin
            if (launch) begin
                done_q  <= 1'b0;
                timed_q <= is_timed;
            end else if (timer_expire) begin
                done_q  <= 1'b1;
            end
            acc_q  <= set_acc  | (acc_q  & ~(stat_wr & bus_wdata[ST_ACC]));
            prot_q <= set_prot | (prot_q & ~(stat_wr & bus_wdata[ST_PROT]));
        end
    end

    // Readback multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_raddr)
            A_DIV: begin
                bus_rdata[DATA_W-1]  = div_loaded;
                bus_rdata[DIV_W-1:0] = div_val;
            end
            A_IDX:   bus_rdata[IDX_W-1:0] = idx_val;
            A_BUF:   bus_rdata = sel_word;
            default: begin
                bus_rdata[ST_DONE] = done_q;
                bus_rdata[ST_ACC]  = acc_q;
                bus_rdata[ST_PROT] = prot_q;
            end
        endcase
    end

    p_launch_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_q) |-> $past(!acc_q && !prot_q));
    p_launch_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(done_q) && timed_q) |-> $past(div_loaded && !clk_slow));
    p_prot_no_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_q) |-> done_q);
    p_timer_tracks_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        timer_active == !done_q);
endmodule

// File: tb/nvm_cmd_front_bench.sv
`timescale 1ns/1ps
module nvm_cmd_front_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [1:0]  bus_raddr = 2'd0;
    logic [15:0] bus_rdata;
    logic        prot_viol = 1'b0;
    logic        clk_slow = 1'b0;
    logic        fclk_tick;
    logic        cmd_busy;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    nvm_cmd_front u_nvm_cmd_front (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .prot_viol(prot_viol), .clk_slow(clk_slow),
        .fclk_tick(fclk_tick), .cmd_busy(cmd_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_raddr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic set_code(input logic [7:0] c);
        wr(2'd1, 16'd0);
        wr(2'd2, {8'd0, c});
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd3, v); check(v == 16'h0080, "R1 status", v, 16'h0080);
        rd(2'd0, v); check(v == 16'h0000, "R1 divider", v, 0);
        rd(2'd2, v); check(v == 16'h0000, "R1 buffer", v, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(fclk_tick == 1'b0, "R3 no tick unloaded", fclk_tick, 0);
        end
    endtask

    task automatic t_unloaded();
        logic [15:0] v;
        set_code(8'h01);
        wr(2'd3, 16'h0080);
        rd(2'd3, v); check(v == 16'h00A0, "R4 unloaded program", v, 16'h00A0);
        set_code(8'h03);
        wr(2'd3, 16'h0080);
        rd(2'd3, v); check(v == 16'h00A0, "R6 blocked by access error", v, 16'h00A0);
        wr(2'd3, 16'h0020);
        rd(2'd3, v); check(v == 16'h0080, "R7 clear access error", v, 16'h0080);
    endtask

    task automatic t_divider();
        logic [15:0] v;
        int gap;
        wr(2'd0, 16'h0003);
        rd(2'd0, v); check(v == 16'h8003, "R2 divider loaded", v, 16'h8003);
        while (!fclk_tick) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!fclk_tick);
        check(gap == 4, "R3 tick period", gap, 4);
    endtask

    task automatic run_timed(input logic [7:0] c, input int exp, input string req);
        int n;
        set_code(c);
        wr(2'd3, 16'h0080);
        check(cmd_busy == 1'b1, req, cmd_busy, 1);
        n = 0;
        while (cmd_busy) begin @(negedge clk); n++; end
        check(n == exp, req, n, exp);
    endtask

    task automatic t_busy_writes();
        logic [15:0] v;
        set_code(8'h02);
        wr(2'd3, 16'h0080);
        wr(2'd0, 16'h0007);
        rd(2'd0, v); check(v == 16'h8003, "R11 divider frozen", v, 16'h8003);
        wr(2'd2, 16'h0055);
        rd(2'd2, v); check(v == 16'h0002, "R10 buffer frozen", v, 2);
        wr(2'd1, 16'h0002);
        rd(2'd1, v); check(v == 16'h0000, "R10 index frozen", v, 0);
        rd(2'd3, v); check(v == 16'h0000, "R12 busy status", v, 0);
        while (cmd_busy) @(negedge clk);
        rd(2'd0, v); check(v == 16'h8003, "R2 loaded persists", v, 16'h8003);
    endtask

    task automatic t_slow();
        logic [15:0] v;
        clk_slow = 1'b1;
        run_timed(8'h03, 5, "R12 verify with slow clock");
        set_code(8'h02);
        wr(2'd3, 16'h0080);
        rd(2'd3, v); check(v == 16'h00A0, "R5 slow clock erase", v, 16'h00A0);
        clk_slow = 1'b0;
        wr(2'd3, 16'h0020);
    endtask

    task automatic t_unknown();
        logic [15:0] v;
        set_code(8'h07);
        wr(2'd3, 16'h0080);
        rd(2'd3, v); check(v == 16'h00A0, "R8 unknown code", v, 16'h00A0);
        wr(2'd3, 16'h0020);
    endtask

    task automatic t_prot();
        logic [15:0] v;
        prot_viol = 1'b1;
        set_code(8'h01);
        wr(2'd3, 16'h0080);
        rd(2'd3, v); check(v == 16'h0090, "R9 protection error", v, 16'h0090);
        prot_viol = 1'b0;
        set_code(8'h03);
        wr(2'd3, 16'h0080);
        rd(2'd3, v); check(v == 16'h0090, "R6 blocked by protection error", v, 16'h0090);
        wr(2'd3, 16'h0010);
        rd(2'd3, v); check(v == 16'h0080, "R7 clear protection error", v, 16'h0080);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unloaded();
        t_divider();
        run_timed(8'h01, 16, "R12 program latency");
        run_timed(8'h02, 24, "R12 erase latency");
        t_busy_writes();
        t_slow();
        t_unknown();
        t_prot();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule